// File: doc/BRIEF.md
# Single-PHY Cell Transmit Controller

This block is the ATM-layer end of a single-PHY transmit link. It pulls octets from an upstream valid/ready stream and presents them to the PHY one per clock. Each octet goes out with an active-low enable and an 8-bit data bus. A start-of-cell flag marks the first octet of every 53-octet cell. Because there is only one PHY, the address bus always carries the all-ones code and never changes.

One input from the PHY controls the flow, and a configuration pin sets how that input is read. In cell mode the input means "a whole cell fits". A cell may start only while it is high, and once a cell has started it runs to its end without further gating. In octet mode the input means "room available". When it drops, the controller may still send up to four octets. It then waits, and it resumes in the same cell, without a new start-of-cell, once room returns.

The upstream stream follows these back-pressure rules. An octet is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` is a combinational function of the flow-control input, the configuration pin and internal state. It never depends on `s_valid`. A source that is not valid simply produces an idle cycle on the PHY side.

Top module: `utx_sphy_tx`

## Requirements
- R1: `tx_addr` is all ones (5'b11111) on every cycle, including during reset.
- R2: In cell mode (`octet_mode`=0), an octet that would be the first of a cell is accepted only on a cycle where `phy_avail` is 1.
- R3: An octet accepted on a cycle (`s_valid` and `s_ready` both 1) appears on `tx_data` with `tx_enb_n`=0 on the following cycle. A cycle without acceptance gives `tx_enb_n`=1 on the following cycle.
- R4: `tx_soc` is 1 exactly on the output cycle of the first octet of each cell (octets counted modulo 53). It is 0 otherwise.
- R5: In octet mode, while `phy_avail` stays 0, no more than 4 octets are accepted, counted from the first cycle on which it is 0. Every cycle with `phy_avail`=1 restores the allowance to 4. After reset the allowance is 0.
- R6: In octet mode, a cell paused by R5 resumes when `phy_avail` returns to 1, with no second `tx_soc` in that cell.
- R7: In cell mode, once a cell has started, `s_ready` stays 1 until its 53rd octet is accepted, whatever the value of `phy_avail`.
- R8: `octet_mode` is taken into account only on a cycle where the next accepted octet would start a cell. The value seen then governs that whole cell.
- R9: A cycle with `s_valid`=0 transfers nothing and does not advance the position within the cell.
- R10: After reset `tx_enb_n`=1, `tx_soc`=0 and `tx_data`=0, and the next accepted octet starts a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| octet_mode | input | 1 | Flow-control mode: 0 cell level, 1 octet level |
| phy_avail | input | 1 | PHY flow input: cell fits (cell mode) or room left (octet mode) |
| s_valid | input | 1 | Upstream octet valid |
| s_data | input | 8 | Upstream octet |
| s_ready | output | 1 | Octet taken when high together with `s_valid` |
| tx_addr | output | 5 | PHY address, fixed all ones |
| tx_enb_n | output | 1 | Active-low enable, low with each octet on the bus |
| tx_data | output | 8 | Octet to the PHY |
| tx_soc | output | 1 | First octet of a cell |

## Verification
The hardest situation to reach from the ports is a configuration change in the middle of a cell. It must not take effect until the cell boundary, while the flow input is low and the octet allowance is being spent. The stimulus starts a cell in octet mode, then flips the pin to cell mode and drops `phy_avail` in the same cycle. This shows that only four octets get through instead of the whole remainder. It then finishes the cell and confirms that the next cell is held back by cell-level gating. Source stalls in the middle of a cell are mixed in so that a stall is not counted as a position step.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int unsigned CELL_OCTETS = 53;
  localparam int unsigned OCTET_W     = 8;
  localparam int unsigned PHY_ADDR_W  = 5;
  localparam int unsigned FULL_SLACK  = 4;

  typedef enum logic {
    FLOW_CELL  = 1'b0,
    FLOW_OCTET = 1'b1
  } flow_mode_e;
endpackage

// File: rtl/utx_pos_track.sv
module utx_pos_track #(
  parameter int unsigned CELL_LEN = utx_pkg::CELL_OCTETS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_in,
  input  logic fire,
  output logic at_boundary,
  output logic oct_eff
);
  localparam int unsigned PW = (CELL_LEN > 1) ? $clog2(CELL_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(CELL_LEN - 1);

  logic [PW-1:0] pos_q;
  logic          mode_q;

  assign at_boundary = (pos_q == '0);
  // mode pin only matters when a new cell is about to begin
  assign oct_eff = at_boundary ? mode_in : mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      mode_q <= 1'b0;
    end else if (fire) begin
      if (at_boundary) mode_q <= mode_in;
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/utx_slack.sv
module utx_slack #(
  parameter int unsigned SLACK = utx_pkg::FULL_SLACK
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_avail,
  input  logic fire,
  output logic has_credit
);
  localparam int unsigned CW = $clog2(SLACK + 1);
  localparam logic [CW-1:0] FULLC = CW'(SLACK);

  logic [CW-1:0] left_q;

  generate
    if (SLACK == 0) begin : g_none
      assign has_credit = 1'b0;
    end else begin : g_cnt
      assign has_credit = (left_q != '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                    left_q <= '0;
    else if (phy_avail)            left_q <= FULLC;
    else if (fire && left_q != '0) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/utx_out_stage.sv
module utx_out_stage #(
  parameter int unsigned DW = utx_pkg::OCTET_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          first,
  input  logic [DW-1:0] din,
  output logic          enb_n,
  output logic          soc,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enb_n <= 1'b1;
      soc   <= 1'b0;
      dout  <= '0;
    end else begin
      enb_n <= ~fire;
      soc   <= fire & first;
      if (fire) dout <= din;
    end
  end
endmodule

// File: rtl/utx_sphy_tx.sv
module utx_sphy_tx #(
  parameter int unsigned DATA_W   = utx_pkg::OCTET_W,
  parameter int unsigned ADDR_W   = utx_pkg::PHY_ADDR_W,
  parameter int unsigned CELL_LEN = utx_pkg::CELL_OCTETS,
  parameter int unsigned SLACK    = utx_pkg::FULL_SLACK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              octet_mode,
  input  logic              phy_avail,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic [ADDR_W-1:0] tx_addr,
  output logic              tx_enb_n,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_soc
);
  import utx_pkg::*;

  logic at_boundary;
  logic oct_eff;
  logic has_credit;
  logic fire;
  logic gate;

  assign tx_addr = '1;

  always_comb begin
    if (flow_mode_e'(oct_eff) == FLOW_OCTET) gate = phy_avail | has_credit;
    else if (at_boundary)                    gate = phy_avail;
    else                                     gate = 1'b1;
  end

  assign s_ready = gate;
  assign fire    = s_valid & gate;

  utx_pos_track #(.CELL_LEN(CELL_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .mode_in(octet_mode), .fire(fire),
    .at_boundary(at_boundary), .oct_eff(oct_eff)
  );

  utx_slack #(.SLACK(SLACK)) u_slack (
    .clk(clk), .rst_n(rst_n), .phy_avail(phy_avail), .fire(fire),
    .has_credit(has_credit)
  );

  utx_out_stage #(.DW(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(fire), .first(at_boundary),
    .din(s_data), .enb_n(tx_enb_n), .soc(tx_soc), .dout(tx_data)
  );
endmodule

// File: rtl/utx_sphy_tx_chk.sv
module utx_sphy_tx_chk #(
  parameter int unsigned SLACK = utx_pkg::FULL_SLACK
) (
  input logic clk,
  input logic rst_n,
  input logic octet_mode,
  input logic phy_avail,
  input logic s_valid,
  input logic s_ready,
  input logic tx_enb_n,
  input logic tx_soc,
  input logic at_boundary,
  input logic oct_eff
);
  logic [7:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n || phy_avail) low_run <= '0;
    else if (s_valid && s_ready && oct_eff && low_run != 8'hFF) low_run <= low_run + 1'b1;
  end

  p_enb_follows_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !tx_enb_n);

  p_idle_when_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> tx_enb_n);

  p_soc_has_enb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |-> !tx_enb_n);

  p_cell_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_soc && !$past(octet_mode)) |-> $past(phy_avail));

  p_cell_runs_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_boundary && !oct_eff) |-> s_ready);

  p_slack_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 8'(SLACK));
endmodule

bind utx_sphy_tx utx_sphy_tx_chk #(.SLACK(SLACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .octet_mode(octet_mode), .phy_avail(phy_avail),
  .s_valid(s_valid), .s_ready(s_ready), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc),
  .at_boundary(at_boundary), .oct_eff(oct_eff)
);

// File: tb/sim_utx_sphy_tx.sv
`timescale 1ns/1ps
module sim_utx_sphy_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic octet_mode = 1'b0;
  logic phy_avail = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready;
  logic [4:0] tx_addr;
  logic tx_enb_n;
  logic [7:0] tx_data;
  logic tx_soc;

  always #5 clk = ~clk;

  utx_sphy_tx u0 (
    .clk(clk), .rst_n(rst_n), .octet_mode(octet_mode), .phy_avail(phy_avail),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .tx_addr(tx_addr),
    .tx_enb_n(tx_enb_n), .tx_data(tx_data), .tx_soc(tx_soc)
  );

  int checks = 0;
  int errors = 0;
  int hs_cnt = 0;
  int soc_cnt = 0;
  int cycles = 0;

  // behavioural reference
  int m_pos = 0;
  int m_left = 0;
  bit m_mode = 0;
  bit e_enb_n = 1;
  bit e_soc = 0;
  logic [7:0] e_data = 8'h00;
  logic [7:0] sent_q[$];

  function automatic bit model_ready();
    bit om;
    om = (m_pos == 0) ? octet_mode : m_mode;
    if (om) return phy_avail || (m_left > 0);
    if (m_pos == 0) return phy_avail;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    bit f;
    if (!rst_n) begin
      m_pos = 0; m_left = 0; m_mode = 0;
      e_enb_n = 1; e_soc = 0; e_data = 8'h00;
    end else begin
      f = s_valid && model_ready();
      e_enb_n = !f;
      e_soc = f && (m_pos == 0);
      if (f) begin
        e_data = s_data;
        sent_q.push_back(s_data);
        if (m_pos == 0) m_mode = octet_mode;
        m_pos = (m_pos == 52) ? 0 : m_pos + 1;
      end
      if (phy_avail) m_left = 4;
      else if (f && m_left > 0) m_left = m_left - 1;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  // one cycle: observe previous result, then drive new inputs
  task automatic step(input bit v, input bit av, input bit md);
    @(negedge clk);
    check("R3 tx_enb_n", tx_enb_n, e_enb_n);
    check("R4 tx_soc", tx_soc, e_soc);
    if (!e_enb_n) check("R3 tx_data", tx_data, e_data);
    check("R1 tx_addr", tx_addr, 5'h1F);
    if (!tx_enb_n && tx_soc) soc_cnt++;
    s_valid = v; phy_avail = av; octet_mode = md;
    #1;
    check("R5 R7 s_ready", s_ready, model_ready());
    if (s_valid && s_ready) begin
      hs_cnt++;
      s_data = s_data + 8'd37;
    end
  endtask

  initial begin
    while (cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog got %0d exp 0", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset enb_n", tx_enb_n, 1);
    check("R10 reset soc", tx_soc, 0);
    check("R10 reset data", tx_data, 0);
    check("R1 reset addr", tx_addr, 5'h1F);
    rst_n = 1'b1;

    // cell mode, PHY has no room: nothing starts
    hs_cnt = 0;
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    check("R2 no start while unavailable", hs_cnt, 0);

    // one available cycle, then low: full cell goes through
    hs_cnt = 0; soc_cnt = 0;
    step(1, 1, 0);
    for (int i = 0; i < 60; i++) step(1, 0, 0);
    step(0, 0, 0);
    check("R7 whole cell despite low avail", hs_cnt, 53);
    check("R4 single soc per cell", soc_cnt, 1);

    // source stalls inside a cell
    hs_cnt = 0; soc_cnt = 0;
    step(1, 1, 0);
    for (int i = 0; i < 120; i++) step(i % 3 != 0, 0, 0);
    step(0, 0, 0);
    check("R9 stalls do not advance position", hs_cnt, 53);
    check("R9 soc once with stalls", soc_cnt, 1);

    // octet mode: pause after four, resume in same cell
    hs_cnt = 0; soc_cnt = 0;
    for (int i = 0; i < 10; i++) step(1, 1, 1);
    check("R5 pre-full octets", hs_cnt, 10);
    hs_cnt = 0;
    for (int i = 0; i < 10; i++) step(1, 0, 1);
    check("R5 at most four after full", hs_cnt, 4);
    hs_cnt = 0;
    for (int i = 0; i < 39; i++) step(1, 1, 1);
    step(0, 1, 1);
    check("R6 resumed remainder", hs_cnt, 39);
    check("R6 no soc on resume", soc_cnt, 1);

    // mode flips mid-cell: octet rules persist to the boundary
    hs_cnt = 0; soc_cnt = 0;
    for (int i = 0; i < 5; i++) step(1, 1, 1);
    hs_cnt = 0;
    for (int i = 0; i < 10; i++) step(1, 0, 0);
    check("R8 mid-cell mode change ignored", hs_cnt, 4);
    hs_cnt = 0;
    for (int i = 0; i < 44; i++) step(1, 1, 0);
    check("R8 cell completes", hs_cnt, 44);
    hs_cnt = 0;
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    check("R8 R2 next cell uses new mode", hs_cnt, 0);
    check("R8 soc count", soc_cnt, 1);

    step(0, 0, 0);
    check("R3 octets sent total", sent_q.size(), 53 * 4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule